// File: doc/BRIEF.md
# Spread-Spectrum Triangle Profile Generator

This block is the digital modulation engine of a spread-spectrum clock synthesizer. Running on the reference clock, it produces a code word that sweeps linearly up and down in a triangle. An external current-output converter turns that code into a small offset on the synthesizer's oscillator, so the output frequency is smeared across a band and the peak of its radiated emission falls. A 2-bit depth selector and a spread-type flag pick one of seven profiles: no modulation, three down-spread depths (1 %, 2 % and 4 % below nominal), and three centered depths (±0.5 %, ±1 % and ±2 %). A multiplier-mode flag picks one of two sweep periods, each a fixed count of reference cycles.

The code is unsigned. In down spread, code 0 is the nominal frequency, and larger codes pull the frequency lower. Code 1016 is the 4 % point. In center spread the nominal point is code 508, and the sweep moves symmetrically around it. The width of a center profile equals the width of the down profile at the same depth code. When the enable input is low, every setting is treated as low and the block idles at the center nominal code. Any change in the effective settings restarts the sweep from the nominal point. The block has no data stream: all of its pins are plain levels, sampled on every reference edge.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first edge with new settings, `mod_code` is 508 and `sweep_rising` is 0.
- R2: While modulating, an internal position t moves by exactly 1 on every clock edge. It runs from 0 up to H, then back down to 0, and repeats. Each turnaround value appears only once (…, H-1, H, H-1, …). `mod_code` equals base + floor(t·P/H), with no jump at a turnaround.
- R3: The peak-to-peak span P is 254 for depth code 01, 508 for 10 and 1016 for 11. `mod_code` never exceeds 1016.
- R4: With depth code 00, `mod_code` holds at 0 when `spread_down`=1, or at 508 when `spread_down`=0. `sweep_rising` is 0.
- R5: Down spread (`spread_down`=1) has base 0 and starts at t=0. Center spread (`spread_down`=0) has base 508−P/2 and starts at t=H/2, which gives code 508.
- R6: H is 374 when `mult_x4`=0 and 562 when `mult_x4`=1. A full sweep therefore takes 748 or 1124 reference cycles.
- R7: While `enable` is low, the block behaves as if the depth code were 00, `spread_down` were 0 and `mult_x4` were 0. `mod_code` is 508.
- R8: If the effective settings (depth code, spread type or multiplier mode) sampled at an edge differ from those at the previous edge, the state reloads at that edge. `mod_code` becomes the start value from R4 or R5, and `sweep_rising` becomes 1 if the depth code is nonzero.
- R9: `sweep_rising` is 1 while t is increasing and 0 while it is decreasing. It changes in the same edge in which t reaches H or 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run when high; when low, all settings are forced low |
| depth_sel | input | 2 | Deviation depth code (00 = no modulation) |
| spread_down | input | 1 | 1 = down spread, 0 = center spread |
| mult_x4 | input | 1 | Selects the longer sweep period |
| mod_code | output | 10 | Code word for the modulation converter |
| sweep_rising | output | 1 | High while the code sweep is ascending |

## Verification
Two events can land on the same edge: a settings change that forces a reload, and a turnaround of the triangle, where the direction flips. The bench provokes this collision in two ways. Directed runs change the depth or multiplier exactly on the edge where the peak or zero is reached. Long random runs change the settings at arbitrary points of the sweep. In every case the bench checks that the reload wins: the code equals the nominal start value and the direction equals the start direction, never the flipped one. A second collision is a change of `enable` while the sweep is running. It is judged the same way, against the forced idle settings.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef struct packed {
    logic [1:0] depth;
    logic       down;
    logic       mult4;
  } ssc_cfg_t;

  localparam ssc_cfg_t SSC_CFG_IDLE = '{depth: 2'b00, down: 1'b0, mult4: 1'b0};
endpackage

// File: rtl/ssc_cfg_gate.sv
module ssc_cfg_gate
  import ssc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic [1:0] depth_sel,
  input  logic     spread_down,
  input  logic     mult_x4,
  output ssc_cfg_t cfg_eff,
  output logic     restart
);
  ssc_cfg_t cfg_prev;

  // disabled: every setting reads as low
  always_comb begin
    if (enable) cfg_eff = '{depth: depth_sel, down: spread_down, mult4: mult_x4};
    else        cfg_eff = SSC_CFG_IDLE;
  end

  assign restart = (cfg_eff != cfg_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_prev <= SSC_CFG_IDLE;
    else        cfg_prev <= cfg_eff;
  end
endmodule

// File: rtl/ssc_step_table.sv
module ssc_step_table
  import ssc_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int T_W      = 10,
  parameter int PEAK_MAX = 1016,
  parameter int QTR_X1   = 187,
  parameter int QTR_X4   = 281
)(
  input  ssc_cfg_t          cfg,
  output logic [CODE_W-1:0] step_q,
  output logic [T_W-1:0]    step_r,
  output logic [T_W-1:0]    half_len,
  output logic [T_W-1:0]    start_t,
  output logic [CODE_W-1:0] start_code,
  output logic              active
);
  localparam int MID     = PEAK_MAX / 2;
  localparam int N_ENTRY = 8;

  logic [CODE_W-1:0] q_tab [N_ENTRY];
  logic [T_W-1:0]    r_tab [N_ENTRY];

  // per (multiplier, depth) quotient and remainder of span / half-period
  for (genvar gm = 0; gm < 2; gm++) begin : g_mult
    for (genvar gd = 0; gd < 4; gd++) begin : g_depth
      localparam int HV = 2 * ((gm == 1) ? QTR_X4 : QTR_X1);
      localparam int PK = (gd == 0) ? 0 : (PEAK_MAX >> (3 - gd));
      assign q_tab[gm*4+gd] = CODE_W'(PK / HV);
      assign r_tab[gm*4+gd] = T_W'(PK % HV);
    end
  end

  logic [2:0] idx;
  assign idx = {cfg.mult4, cfg.depth};

  always_comb begin
    step_q     = q_tab[idx];
    step_r     = r_tab[idx];
    half_len   = cfg.mult4 ? T_W'(2*QTR_X4) : T_W'(2*QTR_X1);
    active     = (cfg.depth != 2'b00);
    start_code = cfg.down ? '0 : CODE_W'(MID);
    if (cfg.down) start_t = '0;
    else          start_t = cfg.mult4 ? T_W'(QTR_X4) : T_W'(QTR_X1);
  end
endmodule

// File: rtl/ssc_tri_engine.sv
module ssc_tri_engine #(
  parameter int CODE_W     = 10,
  parameter int T_W        = 10,
  parameter int RESET_CODE = 508
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              active,
  input  logic [CODE_W-1:0] step_q,
  input  logic [T_W-1:0]    step_r,
  input  logic [T_W-1:0]    half_len,
  input  logic [T_W-1:0]    start_t,
  input  logic [CODE_W-1:0] start_code,
  output logic [CODE_W-1:0] code,
  output logic              rising
);
  logic [T_W-1:0]    pos, pos_n, rem, rem_n;
  logic [CODE_W-1:0] code_n;
  logic              rising_n;
  logic [T_W:0]      rsum;

  // rem tracks (pos * span) mod half_len, so code stays exact floor
  always_comb begin
    rsum = {1'b0, rem} + {1'b0, step_r};
    if (rising) begin
      pos_n    = pos + 1'b1;
      rising_n = (pos_n != half_len);
      if (rsum >= {1'b0, half_len}) begin
        rem_n  = T_W'(rsum - {1'b0, half_len});
        code_n = code + step_q + 1'b1;
      end else begin
        rem_n  = rsum[T_W-1:0];
        code_n = code + step_q;
      end
    end else begin
      pos_n    = pos - 1'b1;
      rising_n = (pos_n == '0);
      if (rem < step_r) begin
        rem_n  = rem + half_len - step_r;
        code_n = code - step_q - 1'b1;
      end else begin
        rem_n  = rem - step_r;
        code_n = code - step_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      rem    <= '0;
      code   <= CODE_W'(RESET_CODE);
      rising <= 1'b0;
    end else if (restart) begin
      pos    <= active ? start_t : '0;
      rem    <= '0;
      code   <= start_code;
      rising <= active;
    end else if (active) begin
      pos    <= pos_n;
      rem    <= rem_n;
      code   <= code_n;
      rising <= rising_n;
    end
  end
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int PEAK_MAX = 1016,
  parameter int QTR_X1   = 187,
  parameter int QTR_X4   = 281
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        depth_sel,
  input  logic              spread_down,
  input  logic              mult_x4,
  output logic [CODE_W-1:0] mod_code,
  output logic              sweep_rising
);
  localparam int QTR_MAX = (QTR_X4 > QTR_X1) ? QTR_X4 : QTR_X1;
  localparam int T_W     = $clog2(2*QTR_MAX + 1);

  ssc_cfg_t          cfg_eff;
  logic              restart, active;
  logic [CODE_W-1:0] step_q, start_code;
  logic [T_W-1:0]    step_r, half_len, start_t;

  ssc_cfg_gate u_gate (
    .clk(clk), .rst_n(rst_n), .enable(enable), .depth_sel(depth_sel),
    .spread_down(spread_down), .mult_x4(mult_x4),
    .cfg_eff(cfg_eff), .restart(restart)
  );

  ssc_step_table #(
    .CODE_W(CODE_W), .T_W(T_W), .PEAK_MAX(PEAK_MAX),
    .QTR_X1(QTR_X1), .QTR_X4(QTR_X4)
  ) u_table (
    .cfg(cfg_eff), .step_q(step_q), .step_r(step_r), .half_len(half_len),
    .start_t(start_t), .start_code(start_code), .active(active)
  );

  ssc_tri_engine #(
    .CODE_W(CODE_W), .T_W(T_W), .RESET_CODE(PEAK_MAX/2)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .restart(restart), .active(active),
    .step_q(step_q), .step_r(step_r), .half_len(half_len),
    .start_t(start_t), .start_code(start_code),
    .code(mod_code), .rising(sweep_rising)
  );
endmodule

// File: rtl/ssc_profile_gen_chk.sv
module ssc_profile_gen_chk #(
  parameter int CODE_W   = 10,
  parameter int PEAK_MAX = 1016
)(
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [1:0]        depth_sel,
  input logic              spread_down,
  input logic              mult_x4,
  input logic [CODE_W-1:0] mod_code,
  input logic              sweep_rising
);
  localparam int MID = PEAK_MAX / 2;
  logic [3:0] cfg_in;
  assign cfg_in = {depth_sel, spread_down, mult_x4};

  a_r3_code_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mod_code <= CODE_W'(PEAK_MAX));

  a_r7_idle_center: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (mod_code == CODE_W'(MID)) && !sweep_rising);

  a_r4_nomod_down: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && depth_sel == 2'b00 && spread_down) |=> (mod_code == '0) && !sweep_rising);

  a_r8_restart_down: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && cfg_in != $past(cfg_in) && depth_sel != 2'b00 && spread_down)
      |=> (mod_code == '0) && sweep_rising);

  a_r5_restart_center: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && cfg_in != $past(cfg_in) && depth_sel != 2'b00 && !spread_down)
      |=> (mod_code == CODE_W'(MID)) && sweep_rising);

  a_r9_rise_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_rising && $past(sweep_rising) && $past(enable) && $past(enable, 2)
     && $past(cfg_in) == $past(cfg_in, 2)) |-> mod_code >= $past(mod_code));
endmodule

bind ssc_profile_gen ssc_profile_gen_chk #(.CODE_W(CODE_W), .PEAK_MAX(PEAK_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .depth_sel(depth_sel),
  .spread_down(spread_down), .mult_x4(mult_x4),
  .mod_code(mod_code), .sweep_rising(sweep_rising)
);

// File: tb/ssc_profile_gen_tb.sv
module ssc_profile_gen_tb;
  localparam int MID = 508;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic [1:0] depth_sel = 2'b11;
  logic       spread_down = 1'b1;
  logic       mult_x4 = 1'b0;
  logic [9:0] mod_code;
  logic       sweep_rising;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic [3:0] m_prev = 4'b0;
  int m_t = 0;
  bit m_dir = 1'b0;

  always #4 clk = ~clk;

  ssc_profile_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .depth_sel(depth_sel),
    .spread_down(spread_down), .mult_x4(mult_x4),
    .mod_code(mod_code), .sweep_rising(sweep_rising)
  );

  function automatic logic [3:0] eff_cfg();
    return enable ? {depth_sel, spread_down, mult_x4} : 4'b0000;
  endfunction

  function automatic int half_of(logic m);
    return m ? 562 : 374;           // R6
  endfunction

  function automatic int peak_of(logic [1:0] d);
    return (d == 2'b00) ? 0 : (1016 >> (3 - d));   // R3
  endfunction

  function automatic int exp_code();
    int pk, base;
    if (m_prev[3:2] == 2'b00) return m_prev[1] ? 0 : MID;  // R4
    pk   = peak_of(m_prev[3:2]);
    base = m_prev[1] ? 0 : MID - pk/2;                     // R5
    return base + (m_t * pk) / half_of(m_prev[0]);         // R2
  endfunction

  task automatic model_edge();
    logic [3:0] e;
    int h;
    e = eff_cfg();
    if (e != m_prev) begin
      m_prev = e;
      if (e[3:2] == 2'b00) begin m_t = 0; m_dir = 1'b0; end
      else begin m_t = e[1] ? 0 : half_of(e[0]) / 2; m_dir = 1'b1; end
    end else if (e[3:2] != 2'b00) begin
      h = half_of(e[0]);
      if (m_dir) begin m_t++; if (m_t == h) m_dir = 1'b0; end
      else       begin m_t--; if (m_t == 0) m_dir = 1'b1; end
    end
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: model follows the edge, outputs compared mid-cycle (R2 R9)
  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check("R2 code", mod_code, exp_code());
      check("R9 dir", sweep_rising, m_dir);
    end
  endtask

  task automatic set_cfg(logic e, logic [1:0] d, logic s, logic m);
    enable = e; depth_sel = d; spread_down = s; mult_x4 = m;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset code", mod_code, MID);
    check("R1 reset dir", sweep_rising, 0);
    rst_n = 1'b1;
    // down, full depth, short period
    run(1);
    check("R8 R5 down start", mod_code, 0);
    check("R8 start dir", sweep_rising, 1);
    run(374);
    check("R3 down peak 11", mod_code, 1016);
    check("R9 turn at top", sweep_rising, 0);
    run(374);
    check("R6 period x1 code", mod_code, 0);
    check("R6 period x1 dir", sweep_rising, 1);
    // center, full depth, long period
    set_cfg(1, 2'b11, 0, 1);
    run(1);
    check("R5 center start", mod_code, MID);
    run(281);
    check("R3 center top", mod_code, 1016);
    run(562);
    check("R5 center bottom", mod_code, 0);
    run(281);
    check("R6 period x4 back to nominal", mod_code, MID);
    // smaller depths
    set_cfg(1, 2'b01, 1, 0);
    run(375);
    check("R3 down peak 01", mod_code, 254);
    set_cfg(1, 2'b10, 0, 0);
    run(188);
    check("R3 center peak 10", mod_code, 762);
    // reload on the turnaround edge: change lands as t would reach bottom
    run(373);
    set_cfg(1, 2'b11, 0, 0);
    run(1);
    check("R8 reload beats turnaround", mod_code, MID);
    check("R8 reload dir", sweep_rising, 1);
    // no modulation
    set_cfg(1, 2'b00, 1, 0);
    run(20);
    check("R4 nomod down", mod_code, 0);
    check("R4 nomod dir", sweep_rising, 0);
    set_cfg(1, 2'b00, 0, 1);
    run(20);
    check("R4 nomod center", mod_code, MID);
    // disable forces idle
    set_cfg(1, 2'b11, 1, 0);
    run(100);
    enable = 1'b0;
    run(1);
    check("R7 disable idle", mod_code, MID);
    run(50);
    check("R7 disable hold", mod_code, MID);
    enable = 1'b1;
    run(120);
    mult_x4 = 1'b1;
    run(1);
    check("R8 mult change restart", mod_code, 0);
    // random settings with occasional changes
    begin
      int seed_v;
      seed_v = $urandom(32'h5eed_1234);
      for (int i = 0; i < 6000; i++) begin
        if (($urandom % 97) == 0)
          set_cfg(($urandom % 8) != 0, 2'($urandom), 1'($urandom), 1'($urandom));
        run(1);
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule